// File: doc/BRIEF.md
# Two-Bank GPIO Controller with Edge Events

This block owns a row of general-purpose pins that are divided at a parameterised boundary into a core bank and a resume bank. Each bank holds eight per-pin registers behind a byte-wide read/write port. Together they set whether a pin is usable, its direction, its output level, which edges it watches, which events are unmasked, and a stored side-channel enable. Every pin has one bit in each register, and eight pins share a byte.

Pin inputs pass through a two-flop synchronizer. The synchronized value is compared with the previous sample to find rising and falling edges. An enabled edge on a usable pin latches a sticky status bit, and software clears that bit by writing a one to it. All status bits whose event enable is set are combined into one level-sensitive event output. Software sees it as an interrupt request that stays high until it clears the cause. The block drives each pad through an output-enable line and a data line.

Top module: `gpio_two_bank`

## Requirements
- R1: Address bit 5 selects the bank (0 core, 1 resume). Address bits 4:2 select the register: 0 usable-enable, 1 direction, 2 level, 3 rise-watch, 4 fall-watch, 5 event-enable, 6 side-enable, 7 status. Address bits 1:0 select the byte. A pin with local index n sits in byte n/8, bit n mod 8, and bits beyond the bank width read 0.
- R2: Pins below RESUME_BASE belong to the core bank with local index equal to the pin number. The remaining pins belong to the resume bank with local index pin minus RESUME_BASE.
- R3: After reset all usable-enables, watch enables, event enables, side enables, levels and status bits are 0. Every direction bit is 1, and event_o and pin_oe_o are 0.
- R4: A direction bit of 1 means input and 0 means output. pin_oe_o is 1 exactly when the pin is usable and is an output, and pin_out_o carries the stored level.
- R5: A write to the level register leaves the stored level of every pin whose direction bit is 1 unchanged.
- R6: A read of the level register returns pin_i after two clock edges of synchronization.
- R7: A rising edge sets the status bit only when rise-watch is 1, and a falling edge only when fall-watch is 1. With both set, either edge sets it.
- R8: Writing 1 to a status bit clears it; writing 0 leaves it unchanged.
- R9: event_o is 1 while any status bit in either bank has its event-enable bit set, and it stays 1 until that condition ends.
- R10: When an edge sets a status bit in the same cycle as a write clears it, the bit ends up set.
- R11: A pin whose usable-enable is 0 never drives pin_oe_o and never sets its status bit.
- R12: Configuration registers read back what was written, masked to the bank's width. The side-enable register affects no other output.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| addr_i | input | 6 | Byte address of the register port |
| wr_en_i | input | 1 | Write strobe for one byte |
| wr_data_i | input | 8 | Write data |
| rd_data_o | output | 8 | Read data for addr_i, combinational |
| pin_i | input | NUM_PINS | Pad input values |
| pin_oe_o | output | NUM_PINS | Pad output enables |
| pin_out_o | output | NUM_PINS | Pad output data |
| event_o | output | 1 | Level-sensitive combined event |

## Verification
The two functions that can meet in one cycle are a status bit being set by a detected edge and the same bit being cleared by a software write of one. The bench raises a watched resume pin and counts the three clock edges of synchronizer and edge-compare latency. It then places the clearing write so that it lands on exactly the edge where the status is captured. The status read afterwards must show the bit set. A second clear one cycle later must then remove it.

// File: rtl/gpio_pkg.sv
package gpio_pkg;
  localparam int ADDR_W     = 6;
  localparam int BANK_SLOTS = 32;

  typedef enum logic [2:0] {
    REG_USE  = 3'd0,
    REG_DIR  = 3'd1,
    REG_LVL  = 3'd2,
    REG_RISE = 3'd3,
    REG_FALL = 3'd4,
    REG_EVT  = 3'd5,
    REG_SIDE = 3'd6,
    REG_STS  = 3'd7
  } gpio_reg_e;
endpackage

// File: rtl/gpio_edge_sync.sv
module gpio_edge_sync #(
  parameter int WIDTH  = 14,
  parameter int STAGES = 2
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [WIDTH-1:0] pin_i,
  output logic [WIDTH-1:0] smp_o,
  output logic [WIDTH-1:0] rise_o,
  output logic [WIDTH-1:0] fall_o
);
  logic [WIDTH-1:0] stage_q [STAGES];
  logic [WIDTH-1:0] prev_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) stage_q[0] <= '0;
    else         stage_q[0] <= pin_i;
  end

  for (genvar s = 1; s < STAGES; s++) begin : g_stage
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) stage_q[s] <= '0;
      else         stage_q[s] <= stage_q[s-1];
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) prev_q <= '0;
    else         prev_q <= stage_q[STAGES-1];
  end

  assign smp_o  = stage_q[STAGES-1];
  assign rise_o = stage_q[STAGES-1] & ~prev_q;
  assign fall_o = ~stage_q[STAGES-1] & prev_q;
endmodule

// File: rtl/gpio_bank.sv
module gpio_bank
  import gpio_pkg::*;
#(
  parameter int WIDTH = 10
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             wr_en_i,
  input  gpio_reg_e        reg_sel_i,
  input  logic [1:0]       byte_sel_i,
  input  logic [7:0]       wr_data_i,
  input  logic [WIDTH-1:0] smp_i,
  input  logic [WIDTH-1:0] rise_i,
  input  logic [WIDTH-1:0] fall_i,
  output logic [7:0]       rd_data_o,
  output logic [WIDTH-1:0] oe_o,
  output logic [WIDTH-1:0] dout_o,
  output logic             evt_o
);
  logic [WIDTH-1:0] use_q, dir_q, lvl_q, rte_q, fte_q, evt_q, side_q, sts_q;
  logic [WIDTH-1:0] wm, wv, set_v, clr_v;
  logic [BANK_SLOTS-1:0] rd_pad;
  logic [WIDTH-1:0] rd_sel;

  // per-pin write lane and value
  always_comb begin
    for (int i = 0; i < WIDTH; i++) begin
      wm[i] = wr_en_i && (2'(i / 8) == byte_sel_i);
      wv[i] = wr_data_i[i % 8];
    end
  end

  function automatic logic [WIDTH-1:0] merge(input logic [WIDTH-1:0] cur,
                                             input logic [WIDTH-1:0] m,
                                             input logic [WIDTH-1:0] v);
    return (cur & ~m) | (v & m);
  endfunction

  assign set_v = use_q & ((rise_i & rte_q) | (fall_i & fte_q));
  assign clr_v = (reg_sel_i == REG_STS) ? (wm & wv) : '0;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      use_q  <= '0;
      dir_q  <= '1;
      lvl_q  <= '0;
      rte_q  <= '0;
      fte_q  <= '0;
      evt_q  <= '0;
      side_q <= '0;
      sts_q  <= '0;
    end else begin
      if (reg_sel_i == REG_USE)  use_q  <= merge(use_q, wm, wv);
      if (reg_sel_i == REG_DIR)  dir_q  <= merge(dir_q, wm, wv);
      if (reg_sel_i == REG_LVL)  lvl_q  <= merge(lvl_q, wm & ~dir_q, wv);
      if (reg_sel_i == REG_RISE) rte_q  <= merge(rte_q, wm, wv);
      if (reg_sel_i == REG_FALL) fte_q  <= merge(fte_q, wm, wv);
      if (reg_sel_i == REG_EVT)  evt_q  <= merge(evt_q, wm, wv);
      if (reg_sel_i == REG_SIDE) side_q <= merge(side_q, wm, wv);
      sts_q <= (sts_q & ~clr_v) | set_v;   // set wins over clear
    end
  end

  always_comb begin
    unique case (reg_sel_i)
      REG_USE:  rd_sel = use_q;
      REG_DIR:  rd_sel = dir_q;
      REG_LVL:  rd_sel = smp_i;
      REG_RISE: rd_sel = rte_q;
      REG_FALL: rd_sel = fte_q;
      REG_EVT:  rd_sel = evt_q;
      REG_SIDE: rd_sel = side_q;
      default:  rd_sel = sts_q;
    endcase
    rd_pad = '0;
    rd_pad[WIDTH-1:0] = rd_sel;
  end

  assign rd_data_o = rd_pad[{byte_sel_i, 3'b000} +: 8];
  assign oe_o      = use_q & ~dir_q;
  assign dout_o    = lvl_q;
  assign evt_o     = |(sts_q & evt_q);

  assert_lvl_hold_input_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    1'b1 |=> (((lvl_q ^ $past(lvl_q)) & $past(dir_q)) == '0));

  assert_set_wins_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (set_v != '0) |=> ((sts_q & $past(set_v)) == $past(set_v)));

  assert_clear_takes_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ((clr_v & ~set_v) != '0) |=> ((sts_q & $past(clr_v & ~set_v)) == '0));

  assert_unusable_no_status_R11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    1'b1 |=> ((sts_q & ~$past(sts_q) & ~$past(use_q)) == '0));

  assert_status_needs_watch_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    1'b1 |=> ((sts_q & ~$past(sts_q) & ~$past((rise_i & rte_q) | (fall_i & fte_q))) == '0));
endmodule

// File: rtl/gpio_two_bank.sv
module gpio_two_bank
  import gpio_pkg::*;
#(
  parameter int NUM_PINS    = 14,
  parameter int RESUME_BASE = 10,
  parameter int SYNC_STAGES = 2
) (
  input  logic                clk_i,
  input  logic                rst_ni,
  input  logic [ADDR_W-1:0]   addr_i,
  input  logic                wr_en_i,
  input  logic [7:0]          wr_data_i,
  output logic [7:0]          rd_data_o,
  input  logic [NUM_PINS-1:0] pin_i,
  output logic [NUM_PINS-1:0] pin_oe_o,
  output logic [NUM_PINS-1:0] pin_out_o,
  output logic                event_o
);
  localparam int CORE_W = RESUME_BASE;
  localparam int RES_W  = NUM_PINS - RESUME_BASE;

  logic [NUM_PINS-1:0] smp, rise, fall;
  logic [7:0]          rd_b [2];
  logic [1:0]          evt_b;
  gpio_reg_e           reg_sel;

  assign reg_sel = gpio_reg_e'(addr_i[4:2]);

  gpio_edge_sync #(.WIDTH(NUM_PINS), .STAGES(SYNC_STAGES)) u_sync (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .pin_i  (pin_i),
    .smp_o  (smp),
    .rise_o (rise),
    .fall_o (fall)
  );

  for (genvar b = 0; b < 2; b++) begin : g_bank
    localparam int W  = (b == 0) ? CORE_W : RES_W;
    localparam int LO = (b == 0) ? 0 : RESUME_BASE;

    gpio_bank #(.WIDTH(W)) u_bank (
      .clk_i      (clk_i),
      .rst_ni     (rst_ni),
      .wr_en_i    (wr_en_i && (addr_i[5] == 1'(b))),
      .reg_sel_i  (reg_sel),
      .byte_sel_i (addr_i[1:0]),
      .wr_data_i  (wr_data_i),
      .smp_i      (smp[LO +: W]),
      .rise_i     (rise[LO +: W]),
      .fall_i     (fall[LO +: W]),
      .rd_data_o  (rd_b[b]),
      .oe_o       (pin_oe_o[LO +: W]),
      .dout_o     (pin_out_o[LO +: W]),
      .evt_o      (evt_b[b])
    );
  end

  assign rd_data_o = rd_b[addr_i[5]];
  assign event_o   = |evt_b;

  assert_evt_holds_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (event_o && !wr_en_i) |=> event_o);
endmodule

// File: tb/gpio_two_bank_tb.sv
module gpio_two_bank_tb;
  localparam int NP = 14;
  localparam int RB = 10;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic [5:0]    addr = '0;
  logic          wr_en = 1'b0;
  logic [7:0]    wdata = '0;
  logic [7:0]    rdata;
  logic [NP-1:0] pins = '0;
  logic [NP-1:0] oe, dout;
  logic          evt;
  int            n_chk = 0, n_fail = 0;

  always #2 clk = ~clk;

  gpio_two_bank #(.NUM_PINS(NP), .RESUME_BASE(RB)) u_dut (
    .clk_i(clk), .rst_ni(rst_n), .addr_i(addr), .wr_en_i(wr_en),
    .wr_data_i(wdata), .rd_data_o(rdata), .pin_i(pins),
    .pin_oe_o(oe), .pin_out_o(dout), .event_o(evt));

  // bank, register index, byte
  function automatic logic [5:0] ad(input int bank, input int rg, input int by);
    return 6'(bank * 32 + rg * 4 + by);
  endfunction

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [5:0] a, input logic [7:0] d);
    @(negedge clk); addr = a; wdata = d; wr_en = 1'b1;
    @(posedge clk);
    @(negedge clk); wr_en = 1'b0;
  endtask

  task automatic rd(input logic [5:0] a, output logic [7:0] d);
    @(negedge clk); addr = a; #1; d = rdata;
  endtask

  task automatic settle(input int n);
    repeat (n) @(posedge clk);
    @(negedge clk);
  endtask

  task automatic t_reset;
    logic [7:0] v;
    rd(ad(0,1,0), v); chk("R3 core dir b0", v, 8'hFF);
    rd(ad(0,1,1), v); chk("R3 R1 core dir b1 width", v, 8'h03);
    rd(ad(1,1,0), v); chk("R3 R1 resume dir", v, 8'h0F);
    rd(ad(0,0,0), v); chk("R3 core use", v, 8'h00);
    rd(ad(1,7,0), v); chk("R3 resume status", v, 8'h00);
    chk("R3 event", evt, 0);
    chk("R3 oe", oe, 0);
  endtask

  task automatic t_readback;
    logic [7:0] v;
    wr(ad(0,6,1), 8'hFF); rd(ad(0,6,1), v); chk("R12 side masked", v, 8'h03);
    wr(ad(1,3,0), 8'hA5); rd(ad(1,3,0), v); chk("R12 R1 rise readback", v, 8'h05);
    chk("R12 side no effect oe", oe, 0);
    chk("R12 side no effect event", evt, 0);
    wr(ad(0,6,1), 8'h00); wr(ad(1,3,0), 8'h00);
  endtask

  task automatic t_output;
    wr(ad(0,0,0), 8'hFF); wr(ad(0,1,0), 8'h00); wr(ad(0,2,0), 8'h5A);
    chk("R4 core out", dout[7:0], 8'h5A);
    chk("R4 core oe", oe[7:0], 8'hFF);
    wr(ad(1,0,0), 8'h0F); wr(ad(1,1,0), 8'h0E); wr(ad(1,2,0), 8'h01);
    chk("R2 R4 resume pin10 out", dout[10], 1);
    chk("R2 R4 resume oe", oe[13:10], 4'b0001);
  endtask

  task automatic t_level_input;
    wr(ad(0,0,1), 8'h02);             // pin9 usable, pin8 not
    wr(ad(0,2,1), 8'h02);             // pin9 still input
    chk("R5 ignored while input", dout[9], 0);
    wr(ad(0,1,1), 8'h00);
    chk("R4 pin9 oe", oe[9], 1);
    chk("R5 level kept after dir", dout[9], 0);
    wr(ad(0,2,1), 8'h02);
    chk("R4 pin9 drives", dout[9], 1);
    chk("R11 pin8 unusable no oe", oe[8], 0);
  endtask

  task automatic t_unusable;
    logic [7:0] v;
    wr(ad(0,3,1), 8'h01);
    pins[8] = 1'b1; settle(4);
    rd(ad(0,7,1), v); chk("R11 unusable no status", v, 8'h00);
  endtask

  task automatic t_sync;
    logic [7:0] v;
    @(negedge clk); pins[3] = 1'b1;
    @(posedge clk); @(negedge clk); addr = ad(0,2,0); #1;
    chk("R6 one edge not yet", rdata[3], 0);
    @(posedge clk); @(negedge clk); #1;
    chk("R6 two edges visible", rdata[3], 1);
    rd(ad(1,2,0), v); chk("R6 resume level", v, 8'h00);
  endtask

  task automatic t_edges;
    logic [7:0] v;
    wr(ad(1,1,0), 8'h0F);
    wr(ad(1,3,0), 8'h05); wr(ad(1,4,0), 8'h06);
    @(negedge clk); pins[12:10] = 3'b111; settle(4);
    rd(ad(1,7,0), v); chk("R7 rising", v, 8'h05);
    wr(ad(1,7,0), 8'h05);
    rd(ad(1,7,0), v); chk("R8 w1c", v, 8'h00);
    @(negedge clk); pins[12:10] = 3'b000; settle(4);
    rd(ad(1,7,0), v); chk("R7 falling", v, 8'h06);
    wr(ad(1,7,0), 8'h00);
    rd(ad(1,7,0), v); chk("R8 write zero kept", v, 8'h06);
    wr(ad(1,7,0), 8'h02);
    rd(ad(1,7,0), v); chk("R8 partial clear", v, 8'h04);
  endtask

  task automatic t_event;
    chk("R9 masked", evt, 0);
    wr(ad(1,5,0), 8'h04);
    chk("R9 asserted", evt, 1);
    settle(3);
    chk("R9 stays", evt, 1);
    wr(ad(1,5,0), 8'h00);
    chk("R9 masked again", evt, 0);
    wr(ad(1,7,0), 8'h04);
    // core bank source
    wr(ad(0,4,0), 8'h08); wr(ad(0,5,0), 8'h08);
    @(negedge clk); pins[3] = 1'b0; settle(4);
    chk("R9 core source", evt, 1);
    wr(ad(0,7,0), 8'h08);
    chk("R9 cleared", evt, 0);
  endtask

  task automatic t_collide;
    logic [7:0] v;
    wr(ad(1,4,0), 8'h00);
    @(negedge clk); pins[10] = 1'b1;
    @(posedge clk); @(posedge clk);
    wr(ad(1,7,0), 8'h01);            // lands on the capture edge
    rd(ad(1,7,0), v); chk("R10 set wins", v, 8'h01);
    wr(ad(1,7,0), 8'h01);
    rd(ad(1,7,0), v); chk("R10 later clear", v, 8'h00);
  endtask

  initial begin
    fork
      begin
        repeat (3) @(posedge clk);
        @(negedge clk); rst_n = 1'b1;
        t_reset(); t_readback(); t_output(); t_level_input(); t_unusable();
        t_sync(); t_edges(); t_event(); t_collide();
      end
      begin
        repeat (20000) @(posedge clk);
        n_chk++; n_fail++;
        $display("FAIL watchdog actual=running expected=done");
      end
    join_any
    disable fork;
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule